// File: doc/BRIEF.md
# Bus Clock-Run Master Controller

This block is the central resource for the clock-run protocol on a secondary parallel bus. It decides, cycle by cycle, whether the buffered bus clock outputs may be gated off, and it is the only party allowed to stop them. Devices on the bus ask for clocks by pulling a shared open-drain, active-low request line; the controller samples that line and can also pull it low itself when it restarts the clocks on its own account.

Stopping is a negotiated event. When an idle request arrives, the minimum-run hold has expired, no serial interrupt is pending and no downstream transfer waits, the controller leaves the line released for a fixed window. Any device that pulls the line low inside the window cancels the stop. A device request always buys a minimum run time; a pending serial interrupt or a downstream transfer keeps the clocks on, or brings them back. Only the master role exists. When the enable strap is low, or while secondary bus reset is active, the clocks run without condition.

The line value presented on `clkrun_n_in` is the resolved bus level, so the controller sees its own drive there. All three outputs come straight from flops and change only on a clock edge.

Top module: `clkrun_master`

## Requirements
- R1: While `run_strap_en` is 0, `bus_clk_en` is 1 from the next edge on and `clkrun_drive` is 0, whatever the other inputs do.
- R2: After `rst_n` is released, and in the cycle after every edge on which `sec_bus_rst` is 1, `bus_clk_en` is 1, `clkrun_drive` is 0 and the minimum-run hold is cleared.
- R3: With the clocks running, no hold left, `idle_req` = 1, `irq_pending` = 0, `xfer_pending` = 0 and the line high (1), the controller enters a stop window of `WIN_CYC` cycles; if nothing cancels it, `bus_clk_en` is 1 for exactly `WIN_CYC` samples after the idle request is taken and then 0.
- R4: A line low (0) seen during the stop window cancels the stop, keeps the clocks on and reloads the minimum-run hold.
- R5: A line low seen while the clocks are stopped turns `bus_clk_en` on at the next edge and keeps it on for at least `HOLD_CYC` cycles; with `idle_req` held at 1 it is on for exactly `HOLD_CYC + WIN_CYC + 1` samples.
- R6: A line low seen while the clocks run reloads the hold to `HOLD_CYC`, so the run time is counted again from the newest request.
- R7: While `irq_pending` is 1, running clocks are never stopped (a stop window in progress is abandoned); if it rises while the clocks are stopped, the controller restarts them as in R8.
- R8: A `xfer_pending` of 1 while the clocks are stopped and the line high makes `clkrun_drive` and `bus_clk_en` 1 at the next edge; `clkrun_drive` stays 1 for exactly one cycle and the restart does not load the hold.
- R9: `clk_run_status` reads 1 exactly when `bus_clk_en` is 1.
- R10: When the line is low and a transfer is pending in the same stopped cycle, the device request wins: clocks restart with the hold loaded and `clkrun_drive` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock (one cycle per bus clock period) |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| sec_bus_rst | input | 1 | Secondary bus reset, active high, synchronous |
| run_strap_en | input | 1 | Clock-run enable strap; 0 keeps clocks on permanently |
| clkrun_n_in | input | 1 | Resolved level of the shared active-low request line |
| idle_req | input | 1 | Request to stop the bus clocks when allowed |
| irq_pending | input | 1 | Serial interrupt detected and not yet cleared |
| xfer_pending | input | 1 | Downstream transfer waiting for the bus |
| bus_clk_en | output | 1 | Enable for the bus clock output buffers |
| clkrun_drive | output | 1 | Pull the request line low when 1 |
| clk_run_status | output | 1 | Readable status: bus clocks currently running |

## Verification
The bench measures the exact length of a run after a device request and after a request renewed halfway through the hold; a design that counts from the first request only, or that is off by one in its hold, shows a different count. It cancels a stop in the middle of the window and expects a full hold afterwards, so a design that ignores the line in the window, or returns without reloading the hold, stops too early. It wakes the bus with a transfer and with a serial interrupt and expects a single-cycle drive pulse, and it collides a device request with a transfer, where a design with the wrong priority would drive the line or skip the hold. It also checks that the controller's own drive, seen back on the line, does not count as a device request.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;
  typedef enum logic [1:0] {
    CR_RUN    = 2'd0,
    CR_WINDOW = 2'd1,
    CR_OFF    = 2'd2,
    CR_WAKE   = 2'd3
  } cr_state_e;
endpackage

// File: rtl/clkrun_hold_timer.sv
module clkrun_hold_timer #(
  parameter int HOLD_CYC = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic dec,
  output logic expired
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (clr)             remain <= '0;
    else if (load)            remain <= LOAD_VAL;
    else if (dec && remain != '0) remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R2: a clear always leaves no hold behind
  p_clr_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> expired);
  // R6: a reload always leaves a non-empty hold
  p_load_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !expired);
endmodule

// File: rtl/clkrun_stop_window.sv
module clkrun_stop_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] START = WW'(WIN_CYC - 1);

  logic [WW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= START;
    else if (dec)  left <= left - 1'b1;
  end

  assign last = (left == '0);

  // R3: the sequencer never counts past the end of the window
  p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !last);
endmodule

// File: rtl/clkrun_ctrl_fsm.sv
module clkrun_ctrl_fsm
  import clkrun_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_rst,
  input  logic strap_en,
  input  logic line_low,
  input  logic idle_req,
  input  logic irq,
  input  logic xfer,
  input  logic hold_expired,
  input  logic win_last,
  output logic hold_clr,
  output logic hold_load,
  output logic hold_dec,
  output logic win_load,
  output logic win_dec,
  output logic clk_en_q,
  output logic drive_q
);
  cr_state_e st, nxt;
  logic keep_on;

  assign keep_on = irq || xfer;

  always_comb begin
    nxt       = st;
    hold_clr  = 1'b0;
    hold_load = 1'b0;
    hold_dec  = 1'b0;
    win_load  = 1'b0;
    win_dec   = 1'b0;
    if (sec_rst || !strap_en) begin
      nxt      = CR_RUN;
      hold_clr = 1'b1;
    end else begin
      unique case (st)
        CR_RUN: begin
          if (line_low)           hold_load = 1'b1;
          else if (!hold_expired) hold_dec  = 1'b1;
          else if (idle_req && !keep_on) begin
            nxt      = CR_WINDOW;
            win_load = 1'b1;
          end
        end
        CR_WINDOW: begin
          if (line_low) begin
            nxt       = CR_RUN;
            hold_load = 1'b1;
          end else if (keep_on) nxt = CR_RUN;
          else if (win_last)   nxt = CR_OFF;
          else                 win_dec = 1'b1;
        end
        CR_OFF: begin
          if (line_low) begin
            nxt       = CR_RUN;
            hold_load = 1'b1;
          end else if (keep_on) nxt = CR_WAKE;
        end
        default: nxt = CR_RUN;  // CR_WAKE: own drive is on the line, not a request
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CR_RUN;
      clk_en_q <= 1'b1;
      drive_q  <= 1'b0;
    end else begin
      st       <= nxt;
      clk_en_q <= (nxt != CR_OFF);
      drive_q  <= (nxt == CR_WAKE);
    end
  end

  // R1: strap low forces running clocks and no drive
  p_strap_forces_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> (clk_en_q && !drive_q));
  // R2: secondary reset gives the reset state
  p_secrst_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rst |=> (clk_en_q && !drive_q && hold_expired));
  // R3: the window holds while nothing interrupts it
  p_window_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CR_WINDOW && !win_last && !line_low && !keep_on && strap_en && !sec_rst)
      |=> (st == CR_WINDOW && clk_en_q));
  // R4: device request inside the window cancels the stop
  p_window_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CR_WINDOW && line_low && strap_en && !sec_rst)
      |=> (st == CR_RUN && !hold_expired));
  // R5: a device request while stopped turns clocks on
  p_dev_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_q && line_low) |=> (clk_en_q && !drive_q));
  // R5: clocks stay on while the hold is not used up
  p_hold_keeps_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_expired |=> clk_en_q);
  // R7: a pending interrupt never lets running clocks stop
  p_irq_keeps_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clk_en_q) |=> clk_en_q);
  // R8: own restart drives the line for one cycle with clocks on
  p_wake_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_q && !line_low && xfer && strap_en && !sec_rst) |=> (drive_q && clk_en_q));
  p_drive_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |=> !drive_q);
endmodule

// File: rtl/clkrun_master.sv
module clkrun_master #(
  parameter int HOLD_CYC = 512,
  parameter int WIN_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_bus_rst,
  input  logic run_strap_en,
  input  logic clkrun_n_in,
  input  logic idle_req,
  input  logic irq_pending,
  input  logic xfer_pending,
  output logic bus_clk_en,
  output logic clkrun_drive,
  output logic clk_run_status
);
  logic hold_clr, hold_load, hold_dec, hold_expired;
  logic win_load, win_dec, win_last;
  logic en_q, drv_q;

  clkrun_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hold_clr),
    .load    (hold_load),
    .dec     (hold_dec),
    .expired (hold_expired)
  );

  clkrun_stop_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (win_load),
    .dec   (win_dec),
    .last  (win_last)
  );

  clkrun_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_rst      (sec_bus_rst),
    .strap_en     (run_strap_en),
    .line_low     (!clkrun_n_in),
    .idle_req     (idle_req),
    .irq          (irq_pending),
    .xfer         (xfer_pending),
    .hold_expired (hold_expired),
    .win_last     (win_last),
    .hold_clr     (hold_clr),
    .hold_load    (hold_load),
    .hold_dec     (hold_dec),
    .win_load     (win_load),
    .win_dec      (win_dec),
    .clk_en_q     (en_q),
    .drive_q      (drv_q)
  );

  assign bus_clk_en     = en_q;
  assign clkrun_drive   = drv_q;
  assign clk_run_status = en_q;

  // R9: status tracks the clock enable at the ports
  p_status_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run_status == bus_clk_en);
endmodule

// File: tb/test_clkrun_master.sv
module test_clkrun_master;
  localparam int HOLD = 512;
  localparam int WIN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_rst = 1'b0, strap = 1'b1, dev_low = 1'b0;
  logic idle = 1'b0, irq = 1'b0, xfer = 1'b0;
  logic en, drv, stat, line_n;

  int n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R2";

  // Reference model state
  int m_mode = 0, m_hold = 0, m_win = 0;
  bit m_en = 1'b1, m_drv = 1'b0;

  assign line_n = ~(dev_low | drv);

  clkrun_master #(.HOLD_CYC(HOLD), .WIN_CYC(WIN)) i_clkrun_master (
    .clk(clk), .rst_n(rst_n), .sec_bus_rst(sec_rst), .run_strap_en(strap),
    .clkrun_n_in(line_n), .idle_req(idle), .irq_pending(irq),
    .xfer_pending(xfer), .bus_clk_en(en), .clkrun_drive(drv),
    .clk_run_status(stat));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, then advance the model just before the next edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(en == m_en, cur_req, en, m_en);
      chk(drv == m_drv, cur_req, drv, m_drv);
      chk(stat == en, "R9", stat, en);
    end
    #3;
    if (!rst_n) begin
      m_mode = 0; m_hold = 0; m_win = 0;
    end else if (!strap || sec_rst) begin
      m_mode = 0; m_hold = 0;
    end else begin
      case (m_mode)
        0: if (!line_n) m_hold = HOLD;
           else if (m_hold > 0) m_hold--;
           else if (idle && !irq && !xfer) begin m_mode = 1; m_win = WIN - 1; end
        1: if (!line_n) begin m_mode = 0; m_hold = HOLD; end
           else if (irq || xfer) m_mode = 0;
           else if (m_win == 0) m_mode = 2;
           else m_win--;
        2: if (!line_n) begin m_mode = 0; m_hold = HOLD; end
           else if (irq || xfer) m_mode = 3;
        default: m_mode = 0;
      endcase
    end
    m_en  = (m_mode != 2);
    m_drv = (m_mode == 3);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_on(output int n);
    n = 0;
    while (en && n < 4000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  initial begin
    int n;
    bit stayed;
    step(3);
    #2 rst_n = 1'b1;
    step(2);
    chk(en == 1'b1, "R2", en, 1);
    chk(drv == 1'b0, "R2", drv, 0);

    // R1: strap low, idle requested, clocks must stay on
    cur_req = "R1";
    strap = 1'b0; idle = 1'b1;
    stayed = 1'b1;
    for (int i = 0; i < 30; i++) begin step(1); if (!en || drv) stayed = 1'b0; end
    chk(stayed, "R1", stayed, 1);
    idle = 1'b0; strap = 1'b1; step(2);

    // R3: plain stop through the window
    cur_req = "R3";
    idle = 1'b1; step(1); idle = 1'b0;
    count_on(n);
    chk(n == WIN, "R3", n, WIN);
    step(5);
    chk(en == 1'b0, "R3", en, 0);

    // R8: downstream transfer restarts with a one-cycle drive
    cur_req = "R8";
    xfer = 1'b1; step(1); xfer = 1'b0;
    chk(drv == 1'b1 && en == 1'b1, "R8", {drv, en}, 3);
    step(1);
    chk(drv == 1'b0 && en == 1'b1, "R8", {drv, en}, 1);
    idle = 1'b1; step(1); idle = 1'b0; step(WIN + 2);
    chk(en == 1'b0, "R3", en, 0);

    // R10 and R5: device request and transfer together while stopped
    cur_req = "R10";
    dev_low = 1'b1; xfer = 1'b1; step(1); dev_low = 1'b0; xfer = 1'b0;
    chk(drv == 1'b0 && en == 1'b1, "R10", {drv, en}, 1);
    cur_req = "R5";
    idle = 1'b1;
    count_on(n);
    chk(n == HOLD + WIN + 1, "R5", n, HOLD + WIN + 1);
    chk(n >= HOLD, "R5", n, HOLD);

    // R6: a renewed request reloads the hold
    cur_req = "R6";
    dev_low = 1'b1; step(1); dev_low = 1'b0;
    step(300);
    dev_low = 1'b1; step(1); dev_low = 1'b0;
    count_on(n);
    chk(n == HOLD + WIN + 1, "R6", n, HOLD + WIN + 1);

    // R4: request inside the stop window cancels it
    cur_req = "R4";
    idle = 1'b0;
    xfer = 1'b1; step(1); xfer = 1'b0; step(2);
    idle = 1'b1; step(1);
    dev_low = 1'b1; step(1); dev_low = 1'b0;
    count_on(n);
    chk(n == HOLD + WIN + 1, "R4", n, HOLD + WIN + 1);

    // R7: pending interrupt wakes and then blocks stopping
    cur_req = "R7";
    idle = 1'b1; irq = 1'b1; step(1);
    chk(drv == 1'b1 && en == 1'b1, "R7", {drv, en}, 3);
    stayed = 1'b1;
    for (int i = 0; i < 30; i++) begin step(1); if (!en) stayed = 1'b0; end
    chk(stayed, "R7", stayed, 1);
    irq = 1'b0; step(1);
    count_on(n);
    chk(n == WIN, "R7", n, WIN);
    idle = 1'b0; xfer = 1'b1; step(1); xfer = 1'b0; step(2);
    idle = 1'b1; step(1); idle = 1'b0; irq = 1'b1; step(1); irq = 1'b0;
    stayed = 1'b1;
    for (int i = 0; i < 10; i++) begin step(1); if (!en) stayed = 1'b0; end
    chk(stayed, "R7", stayed, 1);
    idle = 1'b1; step(1); idle = 1'b0; step(WIN + 2);

    // R2: secondary bus reset while stopped
    cur_req = "R2";
    chk(en == 1'b0, "R2", en, 0);
    sec_rst = 1'b1; idle = 1'b1; step(1);
    chk(en == 1'b1 && drv == 1'b0, "R2", {drv, en}, 1);
    step(3);
    chk(en == 1'b1, "R2", en, 1);
    sec_rst = 1'b0; idle = 1'b0;
    step(4);
    finish_run();
  end
endmodule